// File: doc/BRIEF.md
# NAND Command Word Sequencer

This block sits between a flash driver layer and a NAND controller's register file. Each request names an opcode, an optional column, an optional page, a data length and whether the transfer goes by DMA. The block turns the request into a short, fixed-order burst of register writes on a one-write-per-cycle port:

- a second-command register value;
- the address registers;
- an optional follow-up opcode;
- a data length;
- a packed command word that starts the controller.

After the command word it waits a short settle time. It then polls an interrupt status bus for the completion bit and acknowledges that bit by writing it back. If the bit never comes, it raises a sticky timeout flag.

Program and erase are two-phase operations. The setup opcode (0x80 or 0x60) only prepares the address registers and stores its command word. The confirm opcode (0x10 or 0xD0) later issues the stored word, with the confirm opcode placed in the second-command register. A separate select input picks one of two chip enables. That choice is remembered and merged into every command word built afterwards.

Register selector codes on the write port are:

| Code | Register |
|------|----------|
| 0 | command word |
| 1 | second command |
| 2 | address low |
| 3 | address high |
| 4 | data length |
| 5 | interrupt acknowledge |

Top module: `nand_cmd_seq`

## Requirements
- R1: Every command word has bits 31 and 30 set, bits 29:27 equal to the address-cycle count minus one (truncated to 3 bits, so a count of 0 gives 7), bit 26 as read flag, bit 25 as write flag, bit 19 as chip select, the opcode in bits 7:0 and all other bits zero.
- R2: The chip bit comes from the most recent `sel_valid` pulse (`sel_chip` = 1 sets bit 19). A stored first phase keeps the chip bit it was built with, even if the selection changes before the confirm.
- R3: Address cycles are counted as follows:
  - a column adds 2 cycles;
  - a page adds 2 cycles, plus 1 more when `cfg_dev_log2 > cfg_page_log2 + 16`;
  - with column and page, address low = column and address high = page;
  - with page only, address low = page[15:0] and address high = page >> 16;
  - with column only, only address low is written.
- R4: Opcodes 0x00, 0x05, 0x90 and 0x70 set the read flag. Opcode 0x80 sets the write flag. All other opcodes set neither.
- R5: Read-ID (0x90) and status (0x70) always use exactly one address cycle and write a data length of 4. Other issued commands write `req_len`.
- R6: A setup opcode (0x80 or 0x60) writes only the second-command clear and its address registers, then stores its word and length. A following confirm (0x10 or 0xD0) writes second command = 0x100 | opcode, then the stored length, then the stored word, and releases the store. A confirm with nothing stored makes no writes.
- R7: Every request other than a confirm first writes 0 to the second-command register.
- R8: Opcode 0x00 with `cfg_page_log2 > 9` writes 0x130 to the second-command register after the addresses. Opcode 0x05 writes 0x1E0 there. Opcode 0x00 with 512-byte pages writes no follow-up.
- R9: Completion is `irq_status` bit 31, or bit 28 when `req_dma` is set and the issued word has a read or write flag. On completion the block writes exactly that one-bit mask to the interrupt acknowledge register and becomes ready.
- R10: Polling starts only after SETTLE cycles following the command word, and then samples once every POLL_DIV cycles. With the bit already present, the acknowledge write comes SETTLE+POLL_DIV+1 cycles after the command-word write.
- R11: `err_timeout` is low out of reset. If POLL_MAX samples find no completion bit, it rises SETTLE+POLL_MAX*POLL_DIV+1 cycles after the command-word write and stays high until reset. No acknowledge is written and the block becomes ready.
- R12: Writes go out one per cycle in the order second command, address low, address high, follow-up, length, command word, skipping steps that do not apply. The port is silent when no request is in progress, and `ready` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when ready is high |
| req_op | input | 8 | Opcode |
| req_col_vld | input | 1 | Column present |
| req_col | input | COL_W | Column address |
| req_page_vld | input | 1 | Page present |
| req_page | input | PAGE_W | Page address |
| req_len | input | LEN_W | Data length in bytes |
| req_dma | input | 1 | Transfer uses DMA |
| ready | output | 1 | Idle and able to take a request |
| sel_valid | input | 1 | Chip select update strobe |
| sel_chip | input | 1 | Chip number (0 or 1) |
| cfg_page_log2 | input | PLOG_W | log2 of page size in bytes |
| cfg_dev_log2 | input | DLOG_W | log2 of device size in bytes |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register selector code |
| wr_data | output | 32 | Register write value |
| irq_status | input | 32 | Controller interrupt status |
| err_timeout | output | 1 | Sticky completion timeout |

## Verification
The assertions assume:
- requests arrive only while `ready` is high;
- `irq_status` changes only from a source that has seen the command word;
- a confirm is only counted as consuming a store that actually exists.

The stimulus meets these by driving each request for a single cycle after seeing `ready`. The completion bit is raised only after the command-word write is observed, and is dropped on the acknowledge write. Configuration and chip selection are changed only between requests, so the bench never touches them while the block is busy.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
   localparam int REG_AW = 3;

   // Register selector codes on the write port
   localparam logic [REG_AW-1:0] RG_CMD1  = 3'd0;
   localparam logic [REG_AW-1:0] RG_CMD2  = 3'd1;
   localparam logic [REG_AW-1:0] RG_ADDR1 = 3'd2;
   localparam logic [REG_AW-1:0] RG_ADDR2 = 3'd3;
   localparam logic [REG_AW-1:0] RG_LEN   = 3'd4;
   localparam logic [REG_AW-1:0] RG_IRQ   = 3'd5;

   // Opcodes
   localparam logic [7:0] OP_READ    = 8'h00;
   localparam logic [7:0] OP_RSTART  = 8'h30;
   localparam logic [7:0] OP_ROUT    = 8'h05;
   localparam logic [7:0] OP_ROSTART = 8'hE0;
   localparam logic [7:0] OP_PROG    = 8'h80;
   localparam logic [7:0] OP_PCONF   = 8'h10;
   localparam logic [7:0] OP_ERASE   = 8'h60;
   localparam logic [7:0] OP_ECONF   = 8'hD0;
   localparam logic [7:0] OP_ID      = 8'h90;
   localparam logic [7:0] OP_STAT    = 8'h70;

   localparam logic [31:0] SECOND_FLAG = 32'h0000_0100;
   localparam logic [31:0] DONE_PIO    = 32'h8000_0000;
   localparam logic [31:0] DONE_DMA    = 32'h1000_0000;
   localparam int          SHORT_LEN   = 4;

   typedef enum logic [3:0] {
      S_IDLE, S_CLR2, S_AD1, S_AD2, S_FOL, S_LEN, S_CMD, S_WAIT, S_ACK
   } seq_st_e;
endpackage

// File: rtl/nand_word_build.sv
module nand_word_build
   import nand_seq_pkg::*;
#(
   parameter int PAGE_W = 24,
   parameter int COL_W  = 16,
   parameter int LEN_W  = 12,
   parameter int PLOG_W = 5,
   parameter int DLOG_W = 6
) (
   input  logic [7:0]        op,
   input  logic              col_vld,
   input  logic [COL_W-1:0]  col,
   input  logic              page_vld,
   input  logic [PAGE_W-1:0] page,
   input  logic [LEN_W-1:0]  len,
   input  logic              chip,
   input  logic [PLOG_W-1:0] page_log2,
   input  logic [DLOG_W-1:0] dev_log2,
   output logic [31:0]       word,
   output logic              a1_vld,
   output logic [31:0]       a1_val,
   output logic              a2_vld,
   output logic [31:0]       a2_val,
   output logic              fol_vld,
   output logic [31:0]       fol_val,
   output logic [LEN_W-1:0]  len_out,
   output logic              is_first,
   output logic              is_conf,
   output logic              has_dir
);
   generate
      if (PAGE_W < 17 || PAGE_W > 32 || COL_W > 32 || PLOG_W > 7 || DLOG_W > 7 || LEN_W > 32) begin : g_bad
         $error("nand_word_build: unsupported width parameters");
      end
   endgenerate

   logic       short_cmd, rd, wr, big;
   logic [2:0] cnt, field;
   logic [7:0] dl8, pl8;

   always_comb begin
      short_cmd = (op == OP_ID) || (op == OP_STAT);
      rd        = (op == OP_READ) || (op == OP_ROUT) || short_cmd;
      wr        = (op == OP_PROG);
      dl8       = 8'(dev_log2);
      pl8       = 8'(page_log2) + 8'd16;
      big       = dl8 > pl8;
      cnt       = (col_vld ? 3'd2 : 3'd0) + (page_vld ? (3'd2 + {2'b00, big}) : 3'd0);
      if (short_cmd) cnt = 3'd1;
      field     = cnt - 3'd1;
      word      = {2'b11, field, rd, wr, 5'b0, chip, 11'b0, op};

      a1_vld = col_vld | page_vld;
      a1_val = col_vld ? 32'(col) : {16'b0, page[15:0]};
      a2_vld = page_vld;
      a2_val = col_vld ? 32'(page) : (32'(page) >> 16);

      fol_vld = 1'b0;
      fol_val = 32'b0;
      if (op == OP_READ && page_log2 > PLOG_W'(9)) begin
         fol_vld = 1'b1;
         fol_val = SECOND_FLAG | {24'b0, OP_RSTART};
      end else if (op == OP_ROUT) begin
         fol_vld = 1'b1;
         fol_val = SECOND_FLAG | {24'b0, OP_ROSTART};
      end

      len_out  = short_cmd ? LEN_W'(SHORT_LEN) : len;
      is_first = (op == OP_PROG) || (op == OP_ERASE);
      is_conf  = (op == OP_PCONF) || (op == OP_ECONF);
      has_dir  = rd | wr;
   end
endmodule

// File: rtl/nand_pend_hold.sv
module nand_pend_hold #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             store,
   input  logic [31:0]      word_in,
   input  logic [LEN_W-1:0] len_in,
   input  logic             consume,
   output logic             pend_vld,
   output logic [31:0]      pend_word,
   output logic [LEN_W-1:0] pend_len
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_word <= '0;
         pend_len  <= '0;
      end else if (store) begin
         pend_vld  <= 1'b1;
         pend_word <= word_in;
         pend_len  <= len_in;
      end else if (consume) begin
         pend_vld  <= 1'b0;
      end
   end

   AST_CONSUME_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      consume |-> pend_vld); // R6
   AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vld && !store && !consume) |=> $stable(pend_word) && pend_vld); // R6
endmodule

// File: rtl/nand_done_wait.sv
module nand_done_wait #(
   parameter int SETTLE   = 5,
   parameter int POLL_DIV = 50,
   parameter int POLL_MAX = 500000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [31:0] irq_status,
   input  logic [31:0] mask,
   output logic        hit,
   output logic        timeout
);
   localparam int SW = $clog2(SETTLE + 1);
   localparam int PW = $clog2(POLL_MAX + 1);

   generate
      if (SETTLE < 1 || POLL_DIV < 1 || POLL_MAX < 1) begin : g_bad
         $error("nand_done_wait: SETTLE, POLL_DIV and POLL_MAX must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_POLL} ph_e;
   ph_e           ph;
   logic [SW-1:0] s_cnt;
   logic [PW-1:0] n_cnt;
   logic          tick, seen;

   generate
      if (POLL_DIV > 1) begin : g_div
         localparam int DW = $clog2(POLL_DIV);
         logic [DW-1:0] d_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                          d_cnt <= '0;
            else if (ph != PH_POLL)              d_cnt <= '0;
            else if (d_cnt == DW'(POLL_DIV - 1)) d_cnt <= '0;
            else                                 d_cnt <= d_cnt + 1'b1;
         end
         assign tick = (ph == PH_POLL) && (d_cnt == DW'(POLL_DIV - 1));
      end else begin : g_nodiv
         assign tick = (ph == PH_POLL);
      end
   endgenerate

   assign seen    = |(irq_status & mask);
   assign hit     = tick && seen;
   assign timeout = tick && !seen && (n_cnt == PW'(POLL_MAX - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         s_cnt <= '0;
         n_cnt <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph    <= PH_SETTLE;
               s_cnt <= '0;
            end
            PH_SETTLE: if (s_cnt == SW'(SETTLE - 1)) begin
               ph    <= PH_POLL;
               n_cnt <= '0;
            end else begin
               s_cnt <= s_cnt + 1'b1;
            end
            PH_POLL: if (hit || timeout) ph <= PH_IDLE;
                     else if (tick)      n_cnt <= n_cnt + 1'b1;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !hit && !timeout); // R10
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      (hit || timeout) |=> !hit && !timeout); // R11
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nand_seq_pkg::*;
#(
   parameter int PAGE_W   = 24,
   parameter int COL_W    = 16,
   parameter int LEN_W    = 12,
   parameter int PLOG_W   = 5,
   parameter int DLOG_W   = 6,
   parameter int SETTLE   = 5,
   parameter int POLL_DIV = 50,
   parameter int POLL_MAX = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        req_op,
   input  logic              req_col_vld,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_page_vld,
   input  logic [PAGE_W-1:0] req_page,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_dma,
   output logic              ready,
   input  logic              sel_valid,
   input  logic              sel_chip,
   input  logic [PLOG_W-1:0] cfg_page_log2,
   input  logic [DLOG_W-1:0] cfg_dev_log2,
   output logic              wr_en,
   output logic [2:0]        wr_addr,
   output logic [31:0]       wr_data,
   input  logic [31:0]       irq_status,
   output logic              err_timeout
);
   seq_st_e          state, after_clr, after_ad1, after_ad2, after_fol;
   logic             chip_q;
   logic [31:0]      b_word, b_a1, b_a2, b_fol;
   logic             b_a1v, b_a2v, b_folv, b_first, b_conf, b_dir;
   logic [LEN_W-1:0] b_len;
   logic             p_vld;
   logic [31:0]      p_word;
   logic [LEN_W-1:0] p_len;
   logic             accept, do_store, do_consume, w_hit, w_tmo;

   logic [31:0]      c_word, c_a1, c_a2, c_fol, c_cmd2, c_mask;
   logic             c_a1v, c_a2v, c_folv, c_issue;
   logic [LEN_W-1:0] c_len;

   nand_word_build #(
      .PAGE_W(PAGE_W), .COL_W(COL_W), .LEN_W(LEN_W), .PLOG_W(PLOG_W), .DLOG_W(DLOG_W)
   ) u_build (
      .op(req_op), .col_vld(req_col_vld), .col(req_col), .page_vld(req_page_vld),
      .page(req_page), .len(req_len), .chip(chip_q), .page_log2(cfg_page_log2),
      .dev_log2(cfg_dev_log2), .word(b_word), .a1_vld(b_a1v), .a1_val(b_a1),
      .a2_vld(b_a2v), .a2_val(b_a2), .fol_vld(b_folv), .fol_val(b_fol),
      .len_out(b_len), .is_first(b_first), .is_conf(b_conf), .has_dir(b_dir)
   );

   assign ready      = (state == S_IDLE);
   assign accept     = req_valid && ready;
   assign do_store   = accept && b_first;
   assign do_consume = accept && b_conf && p_vld;

   nand_pend_hold #(.LEN_W(LEN_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .store(do_store), .word_in(b_word), .len_in(b_len),
      .consume(do_consume), .pend_vld(p_vld), .pend_word(p_word), .pend_len(p_len)
   );

   nand_done_wait #(.SETTLE(SETTLE), .POLL_DIV(POLL_DIV), .POLL_MAX(POLL_MAX)) u_wait (
      .clk(clk), .rst_n(rst_n), .start(state == S_CMD), .irq_status(irq_status),
      .mask(c_mask), .hit(w_hit), .timeout(w_tmo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         chip_q <= 1'b0;
      else if (sel_valid) chip_q <= sel_chip;
   end

   always_comb begin
      after_fol = c_issue ? S_LEN : S_IDLE;
      after_ad2 = c_folv  ? S_FOL : after_fol;
      after_ad1 = c_a2v   ? S_AD2 : after_ad2;
      after_clr = c_a1v   ? S_AD1 : after_ad1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         err_timeout <= 1'b0;
         c_word <= '0; c_a1 <= '0; c_a2 <= '0; c_fol <= '0; c_cmd2 <= '0;
         c_mask <= DONE_PIO; c_len <= '0;
         c_a1v <= 1'b0; c_a2v <= 1'b0; c_folv <= 1'b0; c_issue <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (accept) begin
               if (b_conf) begin
                  if (p_vld) begin
                     state   <= S_CLR2;
                     c_cmd2  <= SECOND_FLAG | {24'b0, req_op};
                     c_word  <= p_word;
                     c_len   <= p_len;
                     c_a1v   <= 1'b0;
                     c_a2v   <= 1'b0;
                     c_folv  <= 1'b0;
                     c_issue <= 1'b1;
                     c_mask  <= (req_dma && (p_word[26] || p_word[25])) ? DONE_DMA : DONE_PIO;
                  end
               end else begin
                  state   <= S_CLR2;
                  c_cmd2  <= '0;
                  c_word  <= b_word;
                  c_len   <= b_len;
                  c_a1v   <= b_a1v;  c_a1  <= b_a1;
                  c_a2v   <= b_a2v;  c_a2  <= b_a2;
                  c_folv  <= b_folv; c_fol <= b_fol;
                  c_issue <= !b_first;
                  c_mask  <= (req_dma && b_dir) ? DONE_DMA : DONE_PIO;
               end
            end
            S_CLR2: state <= after_clr;
            S_AD1:  state <= after_ad1;
            S_AD2:  state <= after_ad2;
            S_FOL:  state <= after_fol;
            S_LEN:  state <= S_CMD;
            S_CMD:  state <= S_WAIT;
            S_WAIT: if (w_hit) state <= S_ACK;
                    else if (w_tmo) begin
                       state       <= S_IDLE;
                       err_timeout <= 1'b1;
                    end
            S_ACK:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      wr_en   = 1'b1;
      wr_addr = RG_CMD1;
      wr_data = '0;
      case (state)
         S_CLR2: begin wr_addr = RG_CMD2;  wr_data = c_cmd2;       end
         S_AD1:  begin wr_addr = RG_ADDR1; wr_data = c_a1;         end
         S_AD2:  begin wr_addr = RG_ADDR2; wr_data = c_a2;         end
         S_FOL:  begin wr_addr = RG_CMD2;  wr_data = c_fol;        end
         S_LEN:  begin wr_addr = RG_LEN;   wr_data = 32'(c_len);   end
         S_CMD:  begin wr_addr = RG_CMD1;  wr_data = c_word;       end
         S_ACK:  begin wr_addr = RG_IRQ;   wr_data = c_mask;       end
         default: wr_en = 1'b0;
      endcase
   end

   AST_CMD_WORD_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RG_CMD1) |-> (wr_data[31:30] == 2'b11 && wr_data[24:20] == 5'b0 && wr_data[18:8] == 11'b0)); // R1
   AST_CMD2_CLEARED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready && !b_conf) |=> (wr_en && wr_addr == RG_CMD2 && wr_data == 32'b0)); // R7
   AST_ACK_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RG_IRQ) |-> $past(w_hit)); // R9
   AST_SILENT_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(w_tmo) |-> !wr_en); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |=> err_timeout); // R11
   AST_LEN_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RG_CMD1) |-> $past(wr_en && wr_addr == RG_LEN)); // R12
   AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !wr_en); // R12
endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
   localparam int S = 5;
   localparam int D = 4;
   localparam int M = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_op = 8'h00;
   logic        req_col_vld = 1'b0;
   logic [15:0] req_col = 16'h0;
   logic        req_page_vld = 1'b0;
   logic [23:0] req_page = 24'h0;
   logic [11:0] req_len = 12'h0;
   logic        req_dma = 1'b0;
   logic        ready;
   logic        sel_valid = 1'b0;
   logic        sel_chip = 1'b0;
   logic [4:0]  cfg_page_log2 = 5'd11;
   logic [5:0]  cfg_dev_log2 = 6'd27;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [31:0] wr_data;
   logic [31:0] irq_status = 32'h0;
   logic        err_timeout;

   nand_cmd_seq #(.SETTLE(S), .POLL_DIV(D), .POLL_MAX(M)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_col_vld(req_col_vld), .req_col(req_col), .req_page_vld(req_page_vld),
      .req_page(req_page), .req_len(req_len), .req_dma(req_dma), .ready(ready),
      .sel_valid(sel_valid), .sel_chip(sel_chip), .cfg_page_log2(cfg_page_log2),
      .cfg_dev_log2(cfg_dev_log2), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .irq_status(irq_status), .err_timeout(err_timeout)
   );

   always #10 clk = ~clk;

   int     tests = 0;
   int     fails = 0;
   int     cyc = 0;
   logic [34:0] exp_q[$];
   string  cur_tag = "R12";
   int     mode = 0;
   int     irq_dly = 0;
   logic [31:0] cur_mask = 32'h8000_0000;
   int     c0 = 0;
   int     irq_at = -1;
   int     err_at = -1;
   logic   exp_err = 1'b0;
   bit     m_chip = 1'b0;
   bit     m_pend = 1'b0;
   logic [31:0] m_pword = 32'h0;
   logic [11:0] m_plen = 12'h0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // Monitor: compares the write stream and the error flag with the model on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_tag, " unexpected write"}, {wr_addr, wr_data}, 0);
            end else begin
               logic [34:0] e;
               e = exp_q.pop_front();
               chk({wr_addr, wr_data} == e, cur_tag, {wr_addr, wr_data}, e);
            end
            if (wr_addr == 3'd0) begin
               c0 = cyc;
               if (mode == 0) irq_status <= cur_mask;
               if (mode == 1) irq_at = cyc + irq_dly;
               if (mode == 2) err_at = cyc + S + M * D + 1;
            end
            if (wr_addr == 3'd5) begin
               irq_status <= 32'h0;
               if (mode == 0) chk(cyc == c0 + S + D + 1, "R10 ack timing", cyc - c0, S + D + 1);
            end
         end
         if (mode == 1 && cyc == irq_at) irq_status <= cur_mask;
         if (cyc == err_at) exp_err = 1'b1;
         if (err_timeout !== exp_err) chk(1'b0, "R11 err flag", err_timeout, exp_err);
      end
   end

   function automatic logic [34:0] wv(input logic [2:0] a, input logic [31:0] d);
      return {a, d};
   endfunction

   task automatic sel(input bit c);
      @(negedge clk);
      sel_valid = 1'b1; sel_chip = c;
      @(negedge clk);
      sel_valid = 1'b0;
      m_chip = c;
   endtask

   task automatic run(input string tag, input logic [7:0] op, input bit colv, input logic [15:0] col,
                      input bit pagev, input logic [23:0] page, input logic [11:0] len,
                      input bit dma, input int md, input int dly);
      bit          isid, rd, wr, first, conf;
      int          cnt;
      logic [31:0] w, msk;
      bit          issue;
      cur_tag = tag;
      mode = md; irq_dly = dly;
      isid  = (op == 8'h90) || (op == 8'h70);
      rd    = (op == 8'h00) || (op == 8'h05) || isid;
      wr    = (op == 8'h80);
      first = (op == 8'h80) || (op == 8'h60);
      conf  = (op == 8'h10) || (op == 8'hD0);
      issue = 1'b0;
      if (conf) begin
         if (m_pend) begin
            exp_q.push_back(wv(3'd1, 32'h100 + op));
            exp_q.push_back(wv(3'd4, {20'b0, m_plen}));
            exp_q.push_back(wv(3'd0, m_pword));
            msk = (dma && (m_pword[26] || m_pword[25])) ? 32'h1000_0000 : 32'h8000_0000;
            issue = 1'b1;
            m_pend = 1'b0;
         end
      end else begin
         cnt = 0;
         if (colv) cnt += 2;
         if (pagev) begin
            cnt += 2;
            if (int'(cfg_dev_log2) > int'(cfg_page_log2) + 16) cnt += 1;
         end
         if (isid) cnt = 1;
         w = 32'hC000_0000 | (32'((cnt - 1) & 7) << 27) | (32'(rd) << 26) | (32'(wr) << 25)
             | (32'(m_chip) << 19) | 32'(op);
         exp_q.push_back(wv(3'd1, 32'h0));
         if (colv) exp_q.push_back(wv(3'd2, {16'b0, col}));
         else if (pagev) exp_q.push_back(wv(3'd2, {16'b0, page[15:0]}));
         if (pagev) exp_q.push_back(wv(3'd3, colv ? {8'b0, page} : {24'b0, page[23:16]}));
         if (op == 8'h00 && cfg_page_log2 > 5'd9) exp_q.push_back(wv(3'd1, 32'h130));
         if (op == 8'h05) exp_q.push_back(wv(3'd1, 32'h1E0));
         if (first) begin
            m_pend = 1'b1; m_pword = w; m_plen = isid ? 12'd4 : len;
         end else begin
            exp_q.push_back(wv(3'd4, isid ? 32'd4 : {20'b0, len}));
            exp_q.push_back(wv(3'd0, w));
            issue = 1'b1;
         end
         msk = (dma && (rd || wr)) ? 32'h1000_0000 : 32'h8000_0000;
      end
      cur_mask = msk;
      if (issue && md != 2) exp_q.push_back(wv(3'd5, msk));
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_col_vld = colv; req_col = col;
      req_page_vld = pagev; req_page = page; req_len = len; req_dma = dma;
      @(negedge clk);
      req_valid = 1'b0;
      while (!(ready && exp_q.size() == 0)) @(negedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0 && ready, {tag, " request complete"}, exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1, "R12 reset ready", ready, 1);
      chk(wr_en == 1'b0, "R12 reset no write", wr_en, 0);
      chk(err_timeout == 1'b0, "R11 reset err", err_timeout, 0);

      // R5 read-ID on chip 0, large page device
      sel(1'b0);
      run("R5 read-id", 8'h90, 1, 16'h0, 0, 24'h0, 12'd100, 0, 0, 0);
      // R2 chip 1 merged into status, R5 one cycle even without column
      sel(1'b1);
      run("R2 status chip1", 8'h70, 0, 16'h0, 0, 24'h0, 12'd9, 0, 0, 0);
      // R3 extra cycle, R8 read-start follow-up, delayed completion
      cfg_dev_log2 = 6'd28;
      run("R3 R8 page read big", 8'h00, 1, 16'h0123, 1, 24'hABCDE1, 12'd2112, 0, 1, 7);
      // R3 boundary: dev exactly page<<16, no extra
      cfg_dev_log2 = 6'd27;
      run("R3 boundary", 8'h00, 1, 16'h0040, 1, 24'h000321, 12'd64, 0, 1, 3);
      // R8 small page: no follow-up
      cfg_page_log2 = 5'd9; cfg_dev_log2 = 6'd24;
      run("R8 small page read", 8'h00, 1, 16'h0011, 1, 24'h001234, 12'd528, 0, 0, 0);
      cfg_page_log2 = 5'd11; cfg_dev_log2 = 6'd28;
      // R4 R8 random output, column only
      run("R4 random out", 8'h05, 1, 16'h0800, 0, 24'h0, 12'd64, 0, 0, 0);
      // R6 program: store with chip 1, change chip, confirm with DMA -> bit 28 (R9)
      run("R6 program setup", 8'h80, 1, 16'h0000, 1, 24'h04A5C3, 12'd2112, 0, 0, 0);
      sel(1'b0);
      run("R2 R6 R9 program confirm dma", 8'h10, 0, 16'h0, 0, 24'h0, 12'd0, 1, 0, 0);
      // R6 erase page only, R9 no direction -> bit 31 despite DMA
      run("R3 erase setup", 8'h60, 0, 16'h0, 1, 24'h7B0042, 12'd0, 0, 0, 0);
      run("R9 erase confirm", 8'hD0, 0, 16'h0, 0, 24'h0, 12'd0, 1, 0, 0);
      // R6 confirm with nothing stored: no writes
      run("R6 orphan confirm", 8'h10, 0, 16'h0, 0, 24'h0, 12'd0, 0, 0, 0);
      // R1 no address cycles -> count field 7
      run("R1 reset opcode", 8'hFF, 0, 16'h0, 0, 24'h0, 12'd0, 0, 0, 0);
      // R11 timeout, then normal request still works and flag stays
      run("R11 timeout", 8'h70, 0, 16'h0, 0, 24'h0, 12'd0, 0, 2, 0);
      chk(err_timeout == 1'b1, "R11 err set", err_timeout, 1);
      run("R11 after timeout", 8'h90, 1, 16'h0, 0, 24'h0, 12'd0, 0, 0, 0);
      chk(err_timeout == 1'b1, "R11 err sticky", err_timeout, 1);
      repeat (4) @(negedge clk);
      chk(wr_en == 1'b0, "R12 idle quiet", wr_en, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule